// File: doc/BRIEF.md
# Burst Address Sequencer

This block supplies the word address for a synchronous burst memory port. On every rising clock edge it either captures a fresh external address or, when asked to advance, steps the two lowest address bits through a four-beat group. The upper address bits are held for the whole burst, so a burst never leaves its aligned group of four words.

Either of two strobes can start a burst. One comes from the processor side and counts only while chip enable is high. The other comes from the controller side and always counts. After a load, later addresses come from an internal beat counter that moves only on cycles where the advance input is high. A mode input picks the beat order. In linear order the low bits count up modulo 4. In interleaved order the low bits are the start bits XOR the beat count. Because a load is accepted on any cycle, the burst counter does not have to be used at all.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the address output is all zeros and the wrap flag is 0.
- R2: A controller strobe, or a processor strobe while chip enable is 1, loads the external address on the next rising edge. The output then equals that address, the beat count returns to 0 and the wrap flag clears.
- R3: On an edge with no load and advance at 0, the address output and the wrap flag keep their values.
- R4: Advancing never changes address bits above bit 1. This holds even when those bits are all ones.
- R5: With orderLinear at 1, each advance adds 1 modulo 4 to bits [1:0]. For example, start 10 gives 10, 11, 00, 01.
- R6: With orderLinear at 0 (interleaved, the inactive level), bits [1:0] equal the start bits XOR the beat count. For example, start 01 gives 01, 00, 11, 10.
- R7: A processor strobe while chip enable is 0 is ignored. The edge acts as if that strobe were low.
- R8: A load takes priority over advance on the same edge.
- R9: An advance from the fourth beat returns to the start address and sets the wrap flag. The flag stays set until the next load.
- R10: Loads on consecutive edges each take effect, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| extAddr | input | ADDR_W | External address captured on a load |
| strobeCpu | input | 1 | Processor-side load strobe, qualified by chipEn |
| strobeCtl | input | 1 | Controller-side load strobe, unqualified |
| advance | input | 1 | Step the burst beat |
| chipEn | input | 1 | Chip enable for the processor strobe |
| orderLinear | input | 1 | 1 selects linear order, 0 selects interleaved order |
| curAddr | output | ADDR_W | Current word address |
| wrapped | output | 1 | Set once the burst has passed its fourth beat |

## Verification
The bench builds the block with ADDR_W at 12. This keeps a start address with all upper bits set small enough to write out, so the check that advancing never carries into bit 2 and above runs at that extreme. At this width every one of the four start offsets is also driven in both orders. Consecutive loads are interleaved with partial bursts, so the restart and wrap-clear paths are covered.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } seqCmd_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    strobeCpu,
  input  logic    strobeCtl,
  input  logic    advance,
  input  logic    chipEn,
  output seqCmd_t cmd
);
  logic cpuLoad;

  always_comb begin
    cpuLoad  = strobeCpu & chipEn;
    cmd.load = strobeCtl | cpuLoad;
    // a load always wins over advance
    cmd.step = advance & ~cmd.load;
  end

  a_r7_cpu_gated: assert property (@(posedge clk) disable iff (!rstN)
    (strobeCpu && !chipEn && !strobeCtl) |-> !cmd.load);
  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobeCtl && advance) |-> (cmd.load && !cmd.step));
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              orderLinear,
  input  seqCmd_t           cmd,
  output logic [ADDR_W-1:0] curAddr,
  output logic              wrapped
);
  localparam int BEAT_W   = 2;
  localparam int UPPER_W  = ADDR_W - BEAT_W;
  localparam logic [BEAT_W-1:0] LAST_BEAT = '1;

  logic [UPPER_W-1:0] upperQ;
  logic [BEAT_W-1:0]  startQ;
  logic [BEAT_W-1:0]  beatQ;
  logic               wrapQ;
  logic [BEAT_W-1:0]  lowBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
      wrapQ  <= 1'b0;
    end else if (cmd.load) begin
      upperQ <= extAddr[ADDR_W-1:BEAT_W];
      startQ <= extAddr[BEAT_W-1:0];
      beatQ  <= '0;
      wrapQ  <= 1'b0;
    end else if (cmd.step) begin
      beatQ <= beatQ + 1'b1;
      if (beatQ == LAST_BEAT) wrapQ <= 1'b1;
    end
  end

  always_comb begin
    if (orderLinear) lowBits = startQ + beatQ;
    else             lowBits = startQ ^ beatQ;
  end

  assign curAddr = {upperQ, lowBits};
  assign wrapped = wrapQ;

  a_r2_load_takes: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (curAddr == $past(extAddr) && !wrapped));
  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> $stable(curAddr[ADDR_W-1:BEAT_W]));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.step) |=> ((!$stable(orderLinear) || $stable(curAddr)) && $stable(wrapped)));
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && orderLinear) |=> (!orderLinear || curAddr[BEAT_W-1:0] == $past(curAddr[BEAT_W-1:0]) + 2'd1));
  a_r9_wrap_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && beatQ == LAST_BEAT) |=> wrapped);
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              strobeCpu,
  input  logic              strobeCtl,
  input  logic              advance,
  input  logic              chipEn,
  input  logic              orderLinear,
  output logic [ADDR_W-1:0] curAddr,
  output logic              wrapped
);
  seqCmd_t cmd;

  burst_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strobeCpu(strobeCpu), .strobeCtl(strobeCtl),
    .advance(advance), .chipEn(chipEn), .cmd(cmd)
  );

  burst_seq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .extAddr(extAddr), .orderLinear(orderLinear),
    .cmd(cmd), .curAddr(curAddr), .wrapped(wrapped)
  );
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic          strobeCpu = 1'b0, strobeCtl = 1'b0, advance = 1'b0;
  logic          chipEn = 1'b0, orderLinear = 1'b0;
  logic [AW-1:0] curAddr;
  logic          wrapped;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [AW-1:0] expAddrQ[$];
  logic          expWrapQ[$];
  string         expReqQ[$];

  logic [AW-1:0] mBase = '0;
  logic [1:0]    mBeat = '0;
  logic          mWrap = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .extAddr(extAddr), .strobeCpu(strobeCpu),
    .strobeCtl(strobeCtl), .advance(advance), .chipEn(chipEn),
    .orderLinear(orderLinear), .curAddr(curAddr), .wrapped(wrapped)
  );

  function automatic logic [AW-1:0] modelAddr(input logic lin);
    logic [1:0] lo;
    lo = lin ? (mBase[1:0] + mBeat) : (mBase[1:0] ^ mBeat);
    return {mBase[AW-1:2], lo};
  endfunction

  // driver: drives one edge worth of inputs and queues the expected result
  task automatic step(input logic ce, input logic cpu, input logic ctl,
                      input logic adv, input logic [AW-1:0] a,
                      input logic lin, input string req);
    @(negedge clk);
    chipEn = ce; strobeCpu = cpu; strobeCtl = ctl; advance = adv;
    extAddr = a; orderLinear = lin;
    if (ctl || (cpu && ce)) begin
      mBase = a; mBeat = '0; mWrap = 1'b0;
    end else if (adv) begin
      if (mBeat == 2'd3) mWrap = 1'b1;
      mBeat = mBeat + 2'd1;
    end
    expAddrQ.push_back(modelAddr(lin));
    expWrapQ.push_back(mWrap);
    expReqQ.push_back(req);
  endtask

  // monitor: compares shortly after each edge
  always @(posedge clk) begin
    #2;
    if (expAddrQ.size() > 0) begin
      logic [AW-1:0] ea;
      logic ew;
      string rq;
      ea = expAddrQ.pop_front();
      ew = expWrapQ.pop_front();
      rq = expReqQ.pop_front();
      total++;
      if (curAddr !== ea || wrapped !== ew) begin
        bad++;
        $display("FAIL %s: addr=%h wrap=%b expected addr=%h wrap=%b",
                 rq, curAddr, wrapped, ea, ew);
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    total++;
    if (curAddr !== '0 || wrapped !== 1'b0) begin
      bad++;
      $display("FAIL R1: addr=%h wrap=%b expected addr=%h wrap=0", curAddr, wrapped, {AW{1'b0}});
    end
    // R1: reset state holds while idle (R3)
    step(0, 0, 0, 0, 12'h5A5, 0, "R3");
    // R2: controller strobe load; R5 linear order from start 10
    step(0, 0, 1, 0, 12'h3A6, 1, "R2");
    step(0, 0, 0, 1, 12'h000, 1, "R5");
    step(0, 0, 0, 1, 12'h000, 1, "R5");
    step(0, 0, 0, 1, 12'h000, 1, "R5");
    step(0, 0, 0, 0, 12'h000, 1, "R3");
    // R9: fourth-beat advance wraps and sets flag, then flag sticks
    step(0, 0, 0, 1, 12'h000, 1, "R9");
    step(0, 0, 0, 1, 12'h000, 1, "R9");
    // R2: processor strobe with chip enable clears wrap; R6 interleaved from 01
    step(1, 1, 0, 0, 12'h0F1, 0, "R2");
    step(1, 0, 0, 1, 12'h000, 0, "R6");
    step(1, 0, 0, 1, 12'h000, 0, "R6");
    step(1, 0, 0, 1, 12'h000, 0, "R6");
    step(1, 0, 0, 1, 12'h000, 0, "R9");
    // R7: processor strobe without chip enable is ignored
    step(0, 1, 0, 0, 12'h777, 0, "R7");
    step(0, 1, 0, 1, 12'h777, 0, "R7");
    // R8: load beats advance
    step(0, 0, 1, 1, 12'h452, 1, "R8");
    step(1, 1, 0, 1, 12'h453, 0, "R8");
    // R4: all-ones upper bits, no carry in either order
    step(0, 0, 1, 0, 12'hFFF, 1, "R4");
    step(0, 0, 0, 1, 12'h000, 1, "R4");
    step(0, 0, 0, 1, 12'h000, 1, "R4");
    step(0, 0, 1, 0, 12'hFFE, 0, "R4");
    step(0, 0, 0, 1, 12'h000, 0, "R4");
    step(0, 0, 0, 1, 12'h000, 0, "R4");
    // R10: loads on consecutive edges
    for (int i = 0; i < 4; i++)
      step(i[0], 1'b1, ~i[0], 1'b0, 12'h100 + 12'(i * 5), i[1], "R10");
    // R5/R6: all start offsets in both orders over a full group
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 2; m++) begin
        step(0, 0, 1, 0, 12'h840 + 12'(s), m[0], "R2");
        for (int b = 0; b < 4; b++)
          step(0, 0, 0, 1, 12'h000, m[0], m[0] ? "R5" : "R6");
      end
    end
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule